// File: doc/BRIEF.md
# Timer PWM Output Stage

This block turns a timer's running count and its end-of-period pulse into one pulse-width-modulated output pin. The counter is outside the block. Each cycle the block takes the count value, the one-cycle timeout strobe, a mode select, an idle-level bit and a 16-bit compare value. From these it produces a registered output.

There are two modes. In toggle mode the pin flips at every timeout, which gives a square wave of half the timeout rate. In match mode the pin goes active when the count equals the compare value and drops back to idle at the next timeout, so the compare value sets the duty cycle. The idle bit sets the level the pin rests at, and the active level is its inverse. Changing the mode or the idle bit restarts the output from the new idle level.

Top module: `pwm_timer_out`

## Requirements
- R1: While reset is asserted, and on the first clock after it, the output is 0. This is the idle level, because the idle bit resets to 0.
- R2: With mode = 0 (toggle), each timeout pulse inverts the output. The first timeout after reset or after a settings change drives the output to the active level.
- R3: With mode = 1 (match), a cycle in which the count equals the compare value and no timeout is present drives the output to the active level.
- R4: With mode = 1, a timeout pulse returns the output to the idle level.
- R5: With mode = 1, when the compare equality and the timeout fall in the same cycle, the output is at the idle level afterwards.
- R6: With mode = 1, if the count never equals the compare value during a period, the output stays at the idle level for that whole period.
- R7: The idle level equals the idle bit, and the active level is its inverse (idle bit 1 gives an active-low pin).
- R8: In any cycle where the mode bit or the idle bit differs from its value in the previous cycle, the output goes to the new idle level on the next clock, whatever else happens that cycle.
- R9: The output is registered. A condition that is present at one rising edge shows on the pin right after that edge and not sooner. With no event and no settings change, the pin holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 16 | Current timer count |
| tmo_i | input | 1 | One-cycle timeout strobe from the counter |
| mode_i | input | 1 | 0 = toggle mode, 1 = match mode |
| idle_i | input | 1 | Level the output rests at when not active |
| match_i | input | 16 | Compare value used in match mode |
| pwm_o | output | 1 | Registered PWM output |

## Verification
The block holds only one bit of real state: whether the output is currently active. A corrupted value of that bit shows on the pin at the very next clock as a wrong level. Toggle mode then keeps the wrong phase until the next settings change. Match mode is repaired at the next timeout.

The previous-settings registers are a separate risk. If they go wrong, the output is forced to idle in a cycle where it should not be, or a restart is missed after a settings change, and either shows within one clock. The bench sweeps every compare value from below, inside and beyond a short period, in both modes and with both idle levels, and compares the pin every cycle.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  typedef enum logic {
    PWM_TOGGLE = 1'b0,
    PWM_MATCH  = 1'b1
  } pwm_mode_e;

  // Next value of the "output is active" flag.
  function automatic logic pwm_next_active(
    input pwm_mode_e mode,
    input logic      active,
    input logic      tmo,
    input logic      hit,
    input logic      cfg_chg
  );
    logic nxt;
    if (cfg_chg) begin
      nxt = 1'b0;
    end else if (mode == PWM_TOGGLE) begin
      nxt = active ^ tmo;
    end else if (tmo) begin
      nxt = 1'b0;
    end else if (hit) begin
      nxt = 1'b1;
    end else begin
      nxt = active;
    end
    return nxt;
  endfunction

  // Pin level for a given idle polarity and active flag.
  function automatic logic pwm_pin_level(input logic idle, input logic active);
    return active ? ~idle : idle;
  endfunction

endpackage

// File: rtl/pwm_evt_detect.sv
module pwm_evt_detect #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] match_i,
  input  logic             mode_i,
  input  logic             idle_i,
  output logic             hit_o,
  output logic             cfg_chg_o
);

  logic mode_prev_q;
  logic idle_prev_q;

  assign hit_o = (cnt_i == match_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_prev_q <= 1'b0;
      idle_prev_q <= 1'b0;
    end else begin
      mode_prev_q <= mode_i;
      idle_prev_q <= idle_i;
    end
  end

  assign cfg_chg_o = (mode_prev_q != mode_i) || (idle_prev_q != idle_i);

endmodule

// File: rtl/pwm_state_next.sv
module pwm_state_next
  import pwm_timer_pkg::*;
(
  input  logic mode_i,
  input  logic active_i,
  input  logic tmo_i,
  input  logic hit_i,
  input  logic cfg_chg_i,
  output logic active_nxt_o
);

  pwm_mode_e mode_e;

  always_comb begin
    mode_e       = pwm_mode_e'(mode_i);
    active_nxt_o = pwm_next_active(mode_e, active_i, tmo_i, hit_i, cfg_chg_i);
  end

endmodule

// File: rtl/pwm_out_reg.sv
module pwm_out_reg
  import pwm_timer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active_nxt_i,
  input  logic idle_i,
  output logic active_o,
  output logic pwm_o
);

  logic active_q;
  logic pwm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pwm_q    <= 1'b0;
    end else begin
      active_q <= active_nxt_i;
      pwm_q    <= pwm_pin_level(idle_i, active_nxt_i);
    end
  end

  assign active_o = active_q;
  assign pwm_o    = pwm_q;

  // R7: the pin matches the polarity-adjusted active flag
  a_r7_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pwm_q == (active_q ^ $past(idle_i))));

endmodule

// File: rtl/pwm_timer_out.sv
module pwm_timer_out
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tmo_i,
  input  logic             mode_i,
  input  logic             idle_i,
  input  logic [CNT_W-1:0] match_i,
  output logic             pwm_o
);

  logic hit;
  logic cfg_chg;
  logic active_q;
  logic active_nxt;

  pwm_evt_detect #(.CNT_W(CNT_W)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_i     (cnt_i),
    .match_i   (match_i),
    .mode_i    (mode_i),
    .idle_i    (idle_i),
    .hit_o     (hit),
    .cfg_chg_o (cfg_chg)
  );

  pwm_state_next u_next (
    .mode_i       (mode_i),
    .active_i     (active_q),
    .tmo_i        (tmo_i),
    .hit_i        (hit),
    .cfg_chg_i    (cfg_chg),
    .active_nxt_o (active_nxt)
  );

  pwm_out_reg u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .active_nxt_i (active_nxt),
    .idle_i       (idle_i),
    .active_o     (active_q),
    .pwm_o        (pwm_o)
  );

  // R2: toggle mode flips the pin on a timeout
  a_r2_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && tmo_i && !cfg_chg) |=> (pwm_o != $past(pwm_o)));

  // R3: match mode activates on equality without timeout
  a_r3_match_on: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && hit && !tmo_i && !cfg_chg) |=> (pwm_o == ~$past(idle_i)));

  // R4: match mode timeout returns pin to idle
  a_r4_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && tmo_i) |=> (pwm_o == $past(idle_i)));

  // R5: coincident match and timeout leaves the pin idle
  a_r5_coincide_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && tmo_i && hit) |=> (pwm_o == $past(idle_i)));

  // R8: a settings change restarts from idle
  a_r8_cfg_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (pwm_o == $past(idle_i)));

  // R9: no event, no change: pin holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmo_i && !cfg_chg && !(mode_i && hit)) |=> $stable(pwm_o));

endmodule

// File: tb/pwm_timer_out_bench.sv
module pwm_timer_out_bench;

  localparam int CNT_W  = 16;
  localparam int PERIOD = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CNT_W-1:0] cnt;
  logic             tmo;
  logic             mode;
  logic             idle;
  logic [CNT_W-1:0] mval;
  logic             pwm;

  int n_vec  = 0;
  int n_fail = 0;

  // bench's own view of the output state
  logic on_flag;
  logic last_mode;
  logic last_idle;

  always #4 clk = ~clk;

  pwm_timer_out #(.CNT_W(CNT_W)) u_pwm_timer_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_i   (cnt),
    .tmo_i   (tmo),
    .mode_i  (mode),
    .idle_i  (idle),
    .match_i (mval),
    .pwm_o   (pwm)
  );

  task automatic check(input string tag, input logic got, input logic want);
    n_vec++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s: pwm=%0b expected=%0b (cnt=%0d tmo=%0b mode=%0b idle=%0b match=%0d)",
               tag, got, want, cnt, tmo, mode, idle, mval);
    end
  endtask

  // One clock: drive at falling edge, predict, sample after the rising edge (R9 latency)
  task automatic step(input int c, input logic t, input logic m, input logic il, input int mv);
    string tag;
    logic  eq;
    logic  want;
    @(negedge clk);
    cnt  = CNT_W'(c);
    tmo  = t;
    mode = m;
    idle = il;
    mval = CNT_W'(mv);
    eq   = (c == mv);
    if (m != last_mode || il != last_idle) begin
      tag = "R8";
      on_flag = 1'b0;
    end else if (!m) begin
      tag = t ? "R2" : "R9";
      if (t) on_flag = !on_flag;
    end else if (t && eq) begin
      tag = "R5";
      on_flag = 1'b0;
    end else if (t) begin
      tag = "R4";
      on_flag = 1'b0;
    end else if (eq) begin
      tag = "R3";
      on_flag = 1'b1;
    end else begin
      tag = (mv >= PERIOD) ? "R6" : "R9";
    end
    last_mode = m;
    last_idle = il;
    want = il ? !on_flag : on_flag;   // R7 polarity
    @(posedge clk);
    #1;
    check(tag, pwm, want);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, got=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cnt = '0; tmo = 1'b0; mode = 1'b0; idle = 1'b0; mval = '0;
    on_flag = 1'b0; last_mode = 1'b0; last_idle = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", pwm, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: first clock after reset, nothing happening
    step(1, 1'b0, 1'b0, 1'b0, 0);

    // Sweep: both idle levels, both modes, compare values below/inside/beyond the period
    for (int il = 0; il < 2; il++) begin
      for (int m = 0; m < 2; m++) begin
        for (int mv = 0; mv < PERIOD + 2; mv++) begin
          for (int p = 0; p < 3; p++) begin
            for (int c = 0; c < PERIOD; c++) begin
              step(c, (c == PERIOD - 1), m[0], il[0], mv);
            end
          end
        end
      end
    end

    // R8: settings flip mid-period while a match is present
    step(2, 1'b0, 1'b1, 1'b0, 2);
    step(3, 1'b0, 1'b1, 1'b1, 3);
    step(4, 1'b1, 1'b0, 1'b1, 4);
    step(5, 1'b1, 1'b0, 1'b1, 4);
    step(6, 1'b1, 1'b0, 1'b1, 4);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule